// File: doc/BRIEF.md
# Banked Cache Transaction Spacing Scheduler

This block sits in front of the address and control pins of an external cache. Read and write requests enter with a physical address through a valid/ready handshake. Each accepted request comes out one cycle later as a one-cycle issue strobe, together with its type and the cache address. A programmed size setting fixes which address bit is the top index bit. When banking is switched on, the block drives the complement of that bit on the address line just above it, so that line can act as a chip enable for a second bank of cache devices.

Three control bits decide when a single idle cycle goes between two back-to-back transactions. The first separates every pair of back-to-back reads. The second separates every pair of back-to-back writes. The third separates back-to-back reads only when they fall in different banks. During an inserted idle cycle the block holds ready low, and the requester keeps its request unchanged until it is taken.

Top module: `bank_bubble_sched`

## Requirements
- R1: The size setting `cfg_size` is encoded 0, 1, 2, 3, 4 for 1, 2, 4, 8 and 16 MB. The top index bit is address bit 19 + `cfg_size`. When `cfg_bank_en` is 1 and `cfg_size` < 4, `iss_addr` bit 20 + `cfg_size` carries the complement of request address bit 19 + `cfg_size`, and every other `iss_addr` bit equals the matching request address bit.
- R2: When `cfg_bank_en` is 0, or `cfg_size` is 4, every `iss_addr` bit equals the matching request address bit.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. The following cycle, and only that cycle, shows `iss_stb` = 1, with `iss_wr` (1 = write, 0 = read) and `iss_addr` taken from that request.
- R4: With `cfg_rd_gap` = 1, two reads are never issued in adjacent cycles. A read that directly follows a read is issued with exactly one idle cycle between them, whatever the banks.
- R5: With `cfg_wr_gap` = 1, two writes are never issued in adjacent cycles. A write that directly follows a write is issued with exactly one idle cycle between them, whatever the banks.
- R6: With `cfg_bank_gap` = 1 and banking active (R1 conditions), a read that directly follows a read of the other bank is issued with exactly one idle cycle between them, even when `cfg_rd_gap` = 0. Reads of the same bank and pairs of writes get no added cycle from this control.
- R7: When banking is inactive (`cfg_bank_en` = 0 or `cfg_size` = 4), `cfg_bank_gap` has no effect on issue timing.
- R8: A read that follows a write, a write that follows a read, and any transaction that follows an idle cycle is issued with no added idle cycle.
- R9: After reset `iss_stb` is 0 and `req_ready` is 1, and the first request after reset is accepted at once.
- R10: `req_ready` is 0 exactly in an inserted idle cycle. The pending request is held and then issued with its original type and address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_size | input | 3 | Cache size code, 0..4 for 1..16 MB |
| cfg_bank_en | input | 1 | Enables drive of the bank chip-enable line |
| cfg_rd_gap | input | 1 | Idle cycle between back-to-back reads |
| cfg_wr_gap | input | 1 | Idle cycle between back-to-back writes |
| cfg_bank_gap | input | 1 | Idle cycle between back-to-back reads of different banks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_wr | input | 1 | Request type, 1 = write, 0 = read |
| req_pa | input | 24 | Request physical address bits 23..0 |
| iss_stb | output | 1 | One-cycle issue strobe |
| iss_wr | output | 1 | Type of the issued transaction |
| iss_addr | output | 24 | Cache address of the issued transaction |

## Verification
On every cycle the assertions check that an issue follows each acceptance and nothing else. They also check that no read follows a read, and no write follows a write, in adjacent cycles while the matching control is set, and that no bank-switching read pair is issued back to back under the bank rule. A held request must stay unchanged while ready is low. Exact spacing of one idle cycle, the absence of spacing for mixed types, same-bank reads and inactive banking, and the bit-level address mapping for each size code can only be shown by the bench. It sweeps every size, banking and control combination over every pair of types, same and different banks, and adjacent and spaced requests.

// File: rtl/bsched_pkg.sv
package bsched_pkg;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    // Decoded attributes of one transaction used by the spacing rules
    typedef struct packed {
        op_e  op;
        logic bank;
    } txn_attr_t;

    // Banking is only meaningful when a spare address bit exists above the index MSB
    function automatic logic bank_usable(input logic en, input logic [2:0] size_code,
                                         input int unsigned n_sizes);
        return en && (32'(size_code) < (n_sizes - 1));
    endfunction

endpackage

// File: rtl/bsched_addr_map.sv
module bsched_addr_map #(
    parameter int unsigned MSB_BASE = 19,
    parameter int unsigned N_SIZES  = 5,
    parameter int unsigned SIZE_W   = 3,
    localparam int unsigned ADDR_W  = MSB_BASE + N_SIZES,
    localparam int unsigned POS_W   = $clog2(ADDR_W)
) (
    input  logic [ADDR_W-1:0] pa,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              bank_en,
    output logic [ADDR_W-1:0] addr,
    output logic              bank,
    output logic              bank_on
);
    import bsched_pkg::*;

    logic [SIZE_W-1:0] size_clamp;
    logic [POS_W-1:0]  msb_pos;
    logic [POS_W-1:0]  ce_pos;

    always_comb begin
        if (32'(size_code) > N_SIZES - 1) size_clamp = SIZE_W'(N_SIZES - 1);
        else                              size_clamp = size_code;
        msb_pos = POS_W'(MSB_BASE) + POS_W'(size_clamp);
        ce_pos  = msb_pos + POS_W'(1);
        bank_on = bank_usable(bank_en, 3'(size_clamp), N_SIZES);
        bank    = pa[msb_pos];
        addr    = pa;
        if (bank_on) addr[ce_pos] = ~pa[msb_pos];
    end

endmodule

// File: rtl/bsched_gap_rule.sv
module bsched_gap_rule (
    input  logic                  prev_vld,
    input  bsched_pkg::txn_attr_t prev,
    input  bsched_pkg::txn_attr_t next,
    input  logic                  rd_gap,
    input  logic                  wr_gap,
    input  logic                  bank_gap,
    input  logic                  bank_on,
    output logic                  need_gap
);
    import bsched_pkg::*;

    logic both_rd, both_wr, bank_switch;

    always_comb begin
        both_rd     = (prev.op == OP_RD) && (next.op == OP_RD);
        both_wr     = (prev.op == OP_WR) && (next.op == OP_WR);
        bank_switch = bank_gap && bank_on && (prev.bank != next.bank);
        need_gap    = prev_vld && ((both_rd && (rd_gap || bank_switch)) ||
                                   (both_wr && wr_gap));
    end

endmodule

// File: rtl/bsched_issue_reg.sv
module bsched_issue_reg #(
    parameter int unsigned ADDR_W = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  take,
    input  bsched_pkg::txn_attr_t in_attr,
    input  logic [ADDR_W-1:0]     in_addr,
    output logic                  out_vld,
    output bsched_pkg::txn_attr_t out_attr,
    output logic [ADDR_W-1:0]     out_addr
);
    import bsched_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_attr <= '{op: OP_RD, bank: 1'b0};
            out_addr <= '0;
        end else begin
            out_vld <= take;
            if (take) begin
                out_attr <= in_attr;
                out_addr <= in_addr;
            end
        end
    end

    AST_STROBE_FROM_TAKE: assert property (@(posedge clk) disable iff (rst)
        take |=> out_vld) else $error("issue missing after accept"); // R3

endmodule

// File: rtl/bank_bubble_sched.sv
module bank_bubble_sched #(
    parameter int unsigned MSB_BASE = 19,
    parameter int unsigned N_SIZES  = 5,
    parameter int unsigned SIZE_W   = 3,
    localparam int unsigned ADDR_W  = MSB_BASE + N_SIZES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              cfg_bank_en,
    input  logic              cfg_rd_gap,
    input  logic              cfg_wr_gap,
    input  logic              cfg_bank_gap,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_pa,
    output logic              iss_stb,
    output logic              iss_wr,
    output logic [ADDR_W-1:0] iss_addr
);
    import bsched_pkg::*;

    logic [ADDR_W-1:0] map_addr;
    logic              map_bank;
    logic              bank_on;
    txn_attr_t         new_attr;
    txn_attr_t         last_attr;
    logic              need_gap;
    logic              take;

    bsched_addr_map #(
        .MSB_BASE (MSB_BASE),
        .N_SIZES  (N_SIZES),
        .SIZE_W   (SIZE_W)
    ) i_map (
        .pa        (req_pa),
        .size_code (cfg_size),
        .bank_en   (cfg_bank_en),
        .addr      (map_addr),
        .bank      (map_bank),
        .bank_on   (bank_on)
    );

    always_comb begin
        new_attr.op   = req_wr ? OP_WR : OP_RD;
        new_attr.bank = map_bank;
    end

    bsched_gap_rule i_rule (
        .prev_vld (iss_stb),
        .prev     (last_attr),
        .next     (new_attr),
        .rd_gap   (cfg_rd_gap),
        .wr_gap   (cfg_wr_gap),
        .bank_gap (cfg_bank_gap),
        .bank_on  (bank_on),
        .need_gap (need_gap)
    );

    assign req_ready = !need_gap;
    assign take      = req_valid && req_ready;

    bsched_issue_reg #(.ADDR_W(ADDR_W)) i_issue (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .in_attr  (new_attr),
        .in_addr  (map_addr),
        .out_vld  (iss_stb),
        .out_attr (last_attr),
        .out_addr (iss_addr)
    );

    assign iss_wr = (last_attr.op == OP_WR);

    AST_NO_SPURIOUS_ISSUE: assert property (@(posedge clk) disable iff (rst)
        !take |=> !iss_stb) else $error("issue without accept"); // R3
    AST_RD_RD_SPACED: assert property (@(posedge clk) disable iff (rst)
        (iss_stb && !iss_wr && cfg_rd_gap) |=> !(iss_stb && !iss_wr)) else $error("adjacent reads"); // R4
    AST_WR_WR_SPACED: assert property (@(posedge clk) disable iff (rst)
        (iss_stb && iss_wr && cfg_wr_gap) |=> !(iss_stb && iss_wr)) else $error("adjacent writes"); // R5
    AST_BANK_SWITCH_SPACED: assert property (@(posedge clk) disable iff (rst)
        (iss_stb && !iss_wr && cfg_bank_gap && bank_on) |=>
        !(iss_stb && !iss_wr && (last_attr.bank != $past(last_attr.bank)))) else $error("bank switch adjacent"); // R6
    AST_HELD_REQUEST: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_wr) && $stable(req_pa))) else $error("request dropped"); // R10

endmodule

// File: tb/test_bank_bubble_sched.sv
module test_bank_bubble_sched;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    cfg_size = '0;
    logic          cfg_bank_en = 1'b0, cfg_rd_gap = 1'b0, cfg_wr_gap = 1'b0, cfg_bank_gap = 1'b0;
    logic          req_valid = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_pa = '0;
    logic          req_ready, iss_stb, iss_wr;
    logic [AW-1:0] iss_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_iss = 0;
    int            rec_cyc [4];
    logic          rec_wr  [4];
    logic [AW-1:0] rec_addr[4];

    always #5 clk = ~clk;

    bank_bubble_sched i_bank_bubble_sched (
        .clk(clk), .rst(rst), .cfg_size(cfg_size), .cfg_bank_en(cfg_bank_en),
        .cfg_rd_gap(cfg_rd_gap), .cfg_wr_gap(cfg_wr_gap), .cfg_bank_gap(cfg_bank_gap),
        .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr), .req_pa(req_pa),
        .iss_stb(iss_stb), .iss_wr(iss_wr), .iss_addr(iss_addr)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && iss_stb) begin
            if (n_iss < 4) begin
                rec_cyc[n_iss]  = cyc;
                rec_wr[n_iss]   = iss_wr;
                rec_addr[n_iss] = iss_addr;
            end
            n_iss = n_iss + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] pa, input int sz, input bit be);
        logic [AW-1:0] a = pa;
        if (be && sz < 4) a[20+sz] = ~pa[19+sz];
        return a;
    endfunction

    // Called at a negedge; returns at the negedge after the accepting edge
    task automatic push(input bit wr, input logic [AW-1:0] pa, output int stalls);
        bit ok;
        stalls = 0;
        req_valid = 1'b1; req_wr = wr; req_pa = pa;
        forever begin
            #4;
            ok = req_ready;
            @(posedge clk);
            if (ok) break;
            stalls++;
        end
        @(negedge clk);
    endtask

    task automatic run_pair(input int sz, input bit be, input bit wa, input bit wb,
                            input bit diff, input bit consec);
        logic [AW-1:0] pa_a, pa_b;
        int sa, sb, gap_exp;
        bit bub, bank_rule;
        string tag;
        pa_a = AW'($urandom);
        pa_b = AW'($urandom);
        pa_a[19+sz] = 1'b0;
        pa_b[19+sz] = diff;
        n_iss = 0;
        push(wa, pa_a, sa);
        if (!consec) begin
            req_valid = 1'b0;
            @(negedge clk);
        end
        push(wb, pa_b, sb);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);

        bank_rule = cfg_bank_gap && be && (sz < 4) && diff;
        bub = consec && ((!wa && !wb && (cfg_rd_gap || bank_rule)) || (wa && wb && cfg_wr_gap));
        if (bub && !wa && !cfg_rd_gap)      tag = "R6";
        else if (bub && !wa)                tag = "R4";
        else if (bub)                       tag = "R5";
        else if (cfg_bank_gap && diff && !(be && sz < 4)) tag = "R7";
        else                                tag = "R8";
        gap_exp = (bub || !consec) ? 2 : 1;

        chk(n_iss == 2, "R3 issue count", n_iss, 2);
        chk(rec_wr[0] == wa && rec_wr[1] == wb, "R3 issue type", {rec_wr[0], rec_wr[1]}, {wa, wb});
        chk(rec_cyc[1] - rec_cyc[0] == gap_exp, tag, rec_cyc[1] - rec_cyc[0], gap_exp);
        chk(sa == 0, "R10 first stalls", sa, 0);
        chk(sb == (bub ? 1 : 0), "R10 stall cycles", sb, bub ? 1 : 0);
        chk(rec_addr[0] == exp_addr(pa_a, sz, be), (be && sz < 4) ? "R1 addr" : "R2 addr",
            rec_addr[0], exp_addr(pa_a, sz, be));
        chk(rec_addr[1] == exp_addr(pa_b, sz, be), (be && sz < 4) ? "R1 addr" : "R2 addr",
            rec_addr[1], exp_addr(pa_b, sz, be));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(iss_stb == 1'b0, "R9 strobe after reset", iss_stb, 0);
        chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
        // First request after reset with all spacing controls on
        cfg_rd_gap = 1'b1; cfg_wr_gap = 1'b1; cfg_bank_gap = 1'b1; cfg_bank_en = 1'b1;
        n_iss = 0;
        push(1'b0, 24'h12_3456, s);
        req_valid = 1'b0;
        chk(s == 0, "R9 first accept", s, 0);
        repeat (2) @(negedge clk);
        chk(n_iss == 1, "R9 first issue", n_iss, 1);

        for (int sz = 0; sz < 5; sz++)
            for (int be = 0; be < 2; be++)
                for (int ctl = 0; ctl < 8; ctl++) begin
                    cfg_size = 3'(sz); cfg_bank_en = be[0];
                    cfg_rd_gap = ctl[0]; cfg_wr_gap = ctl[1]; cfg_bank_gap = ctl[2];
                    @(negedge clk);
                    for (int ops = 0; ops < 4; ops++)
                        for (int d = 0; d < 2; d++)
                            for (int c = 0; c < 2; c++)
                                run_pair(sz, be[0], ops[1], ops[0], d[0], c[0]);
                end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule